// File: doc/BRIEF.md
# Banked Binary-Point Register Bank

This block holds the per-processor priority mask and binary-point state of an interrupt controller's processor interface. A small register bus drives it: an offset, a write enable, write data, a processor index and a flag that marks the access as non-secure. Reads are combinational from the current state. Writes land on the rising clock edge.

Two elaboration-time parameters shape the behaviour. `HAS_SEC` selects whether security extensions are present. `REV` selects the architecture revision.

With security extensions, the binary-point offset is banked by the security state of the access. A secure access reaches the secure copy. A non-secure access reaches a separate non-secure copy, and that copy lives in the alias storage. Without security extensions, the alias offset can act as a clamped, mirrored view of the binary point (revision 2 and later) or be inert (revision 1). The minimum-value clamp keeps the non-secure grouping threshold at 1 or above.

Top module: `cpuif_bpr_bank`

## Requirements
- R1: Offset 0x04 is an 8-bit priority mask. A write stores the low 8 bits of the write data, and a read returns them zero-extended.
- R2: A write to offset 0x08 or 0x1C keeps only bits [2:0] of the write data. Reads of either offset return zero in bits [31:3].
- R3: With security extensions, a secure access to 0x08 reads and writes the secure copy. A non-secure access to 0x08 reads and writes the non-secure copy. Neither access disturbs the other copy.
- R4: Every write into the non-secure copy under security extensions is clamped, so a value of 0 is stored as 1. This covers a non-secure write to 0x08 and a secure write to 0x1C.
- R5: A read of 0x1C returns zero unless security extensions are present and the access is secure. In that case it returns the non-secure copy.
- R6: With security extensions, a secure write to 0x1C updates the non-secure copy, with the clamp. A non-secure write to 0x1C changes nothing visible at offsets 0x08 or 0x1C.
- R7: Without security extensions at revision 2 or later, a write to 0x1C stores the clamped value in the alias storage and also places that clamped value in the binary point read at 0x08. A write to 0x08 stores its low 3 bits unclamped.
- R8: Without security extensions at revision 1, a write to 0x1C has no effect on the value read at 0x08.
- R9: Each processor index 0 to NUM_CPU-1 has its own copy of every register. A write to one index leaves the other indices unchanged.
- R10: An access whose processor index is NUM_CPU or more reads zero, and its writes are ignored.
- R11: After reset the priority mask and the secure binary point read 0. The non-secure copy reads 1.
- R12: Offsets other than 0x04, 0x08 and 0x1C read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (8) | Register byte offset |
| wrEn | input | 1 | Write enable |
| wrData | input | DATA_W (32) | Write data |
| cpuIdx | input | IDX_W (3) | Processor index selecting the bank |
| nonSecure | input | 1 | High for a non-secure access |
| rdData | output | DATA_W (32) | Combinational read data |

## Verification
The hardest case to reach is alias storage that changed but cannot be read at the alias offset. Without security extensions, every read of 0x1C returns zero, so the value written there is visible only through the binary point it copies into. The bench therefore writes 0x1C with values at and below the minimum and then reads 0x08, on both revisions side by side. The revision-1 instance must keep its old value, while the revision-2 instance must show the clamped one. Three instances share one bus, so every access sequence is checked against all three configurations at once, including the out-of-range indices 6 and 7.

// File: rtl/cpuif_bpr_pkg.sv
package cpuif_bpr_pkg;
  // byte offsets of the register window
  localparam int OFS_PMASK = 'h04;
  localparam int OFS_BP    = 'h08;
  localparam int OFS_ABP   = 'h1C;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_PMASK = 2'd1,
    RD_SECBP = 2'd2,
    RD_ALIAS = 2'd3
  } rdSel_e;

  // strobes from decode to storage
  typedef struct packed {
    logic   maskWe;
    logic   secWe;
    logic   aliasWe;
    logic   aliasClamp;
    logic   secTakesClamp;
    rdSel_e rdSel;
  } bprStrobe_t;
endpackage

// File: rtl/cpuif_bpr_ctrl.sv
module cpuif_bpr_ctrl
  import cpuif_bpr_pkg::*;
#(
  parameter int NUM_CPU = 6,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 8,
  parameter bit HAS_SEC = 1'b1,
  parameter int REV     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic              nonSecure,
  output bprStrobe_t        stb
);
  localparam bit MIRROR = !HAS_SEC && (REV >= 2);

  logic idxOk;
  assign idxOk = (int'(cpuIdx) < NUM_CPU);

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (idxOk) begin
      if (addr == ADDR_W'(OFS_PMASK)) begin
        stb.rdSel  = RD_PMASK;
        stb.maskWe = wrEn;
      end else if (addr == ADDR_W'(OFS_BP)) begin
        if (HAS_SEC && nonSecure) begin
          stb.rdSel      = RD_ALIAS;
          stb.aliasWe    = wrEn;
          stb.aliasClamp = 1'b1;
        end else begin
          stb.rdSel   = RD_SECBP;
          stb.secWe   = wrEn;
          stb.aliasWe = wrEn && MIRROR;
        end
      end else if (addr == ADDR_W'(OFS_ABP)) begin
        if (HAS_SEC) begin
          if (!nonSecure) begin
            stb.rdSel      = RD_ALIAS;
            stb.aliasWe    = wrEn;
            stb.aliasClamp = 1'b1;
          end
        end else if (MIRROR) begin
          stb.aliasWe       = wrEn;
          stb.aliasClamp    = 1'b1;
          stb.secWe         = wrEn;
          stb.secTakesClamp = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpuif_bpr_dpath.sv
module cpuif_bpr_dpath
  import cpuif_bpr_pkg::*;
#(
  parameter int NUM_CPU   = 6,
  parameter int IDX_W     = 3,
  parameter int DATA_W    = 32,
  parameter int MASK_W    = 8,
  parameter int BP_W      = 3,
  parameter int ALIAS_MIN = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bprStrobe_t        stb,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [BP_W-1:0] MIN_BP = BP_W'(ALIAS_MIN);

  logic [BP_W-1:0] newBp;
  logic [BP_W-1:0] clampBp;
  logic [DATA_W-1:0] part [NUM_CPU];

  assign newBp   = wrData[BP_W-1:0];
  assign clampBp = (newBp < MIN_BP) ? MIN_BP : newBp;

  for (genvar g = 0; g < NUM_CPU; g++) begin : gCpu
    logic              hit;
    logic [MASK_W-1:0] maskQ;
    logic [BP_W-1:0]   secQ;
    logic [BP_W-1:0]   aliasQ;

    assign hit = (cpuIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ  <= '0;
        secQ   <= '0;
        aliasQ <= MIN_BP;
      end else if (hit) begin
        if (stb.maskWe)  maskQ  <= wrData[MASK_W-1:0];
        if (stb.secWe)   secQ   <= stb.secTakesClamp ? clampBp : newBp;
        if (stb.aliasWe) aliasQ <= stb.aliasClamp ? clampBp : newBp;
      end
    end

    always_comb begin
      part[g] = '0;
      if (hit) begin
        unique case (stb.rdSel)
          RD_PMASK: part[g] = DATA_W'(maskQ);
          RD_SECBP: part[g] = DATA_W'(secQ);
          RD_ALIAS: part[g] = DATA_W'(aliasQ);
          default:  part[g] = '0;
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CPU; i++) rdData = rdData | part[i];
  end
endmodule

// File: rtl/cpuif_bpr_bank.sv
module cpuif_bpr_bank
  import cpuif_bpr_pkg::*;
#(
  parameter int NUM_CPU   = 6,
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int MASK_W    = 8,
  parameter int BP_W      = 3,
  parameter int ALIAS_MIN = 1,
  parameter bit HAS_SEC   = 1'b1,
  parameter int REV       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic              nonSecure
);
  bprStrobe_t stb;

  cpuif_bpr_ctrl #(
    .NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .HAS_SEC(HAS_SEC), .REV(REV)
  ) u_ctrl (
    .addr(addr), .wrEn(wrEn), .cpuIdx(cpuIdx),
    .nonSecure(nonSecure), .stb(stb)
  );

  cpuif_bpr_dpath #(
    .NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .DATA_W(DATA_W),
    .MASK_W(MASK_W), .BP_W(BP_W), .ALIAS_MIN(ALIAS_MIN)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuIdx(cpuIdx),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/cpuif_bpr_chk.sv
module cpuif_bpr_chk #(
  parameter int NUM_CPU   = 6,
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int MASK_W    = 8,
  parameter int BP_W      = 3,
  parameter int ALIAS_MIN = 1,
  parameter bit HAS_SEC   = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [IDX_W-1:0]  cpuIdx,
  input logic              nonSecure
);
  logic isMask, isBp, isAbp, inRange;
  assign isMask  = (addr == ADDR_W'('h04));
  assign isBp    = (addr == ADDR_W'('h08));
  assign isAbp   = (addr == ADDR_W'('h1C));
  assign inRange = (int'(cpuIdx) < NUM_CPU);

  p_mask_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn && isMask && inRange) && isMask && cpuIdx == $past(cpuIdx))
      |-> rdData == DATA_W'($past(wrData[MASK_W-1:0])));

  p_bp_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isBp || isAbp) |-> (rdData >> BP_W) == '0);

  p_ns_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_SEC && nonSecure && isBp && inRange) |-> rdData >= DATA_W'(ALIAS_MIN));

  p_alias_hidden_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isAbp && (!HAS_SEC || nonSecure)) |-> rdData == '0);

  p_oob_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> rdData == '0);

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(isMask || isBp || isAbp) |-> rdData == '0);
endmodule

bind cpuif_bpr_bank cpuif_bpr_chk #(
  .NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .MASK_W(MASK_W), .BP_W(BP_W), .ALIAS_MIN(ALIAS_MIN), .HAS_SEC(HAS_SEC)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .cpuIdx(cpuIdx), .nonSecure(nonSecure)
);

// File: tb/cpuif_bpr_bank_tb.sv
module cpuif_bpr_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 3;
  localparam int NCPU = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] addr = '0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [2:0] cpuIdx = '0;
  logic nonSecure = 1'b0;
  logic [31:0] rd [NCFG];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // configuration 0: security present rev 2; 1: none rev 2; 2: none rev 1
  int cfgSec [NCFG] = '{1, 0, 0};
  int cfgRev [NCFG] = '{2, 2, 1};
  int mMask [NCFG][8];
  int mSec [NCFG][8];
  int mAlias [NCFG][8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuif_bpr_bank #(.HAS_SEC(1'b1), .REV(2)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rd[0]), .cpuIdx(cpuIdx), .nonSecure(nonSecure));
  cpuif_bpr_bank #(.HAS_SEC(1'b0), .REV(2)) u_dut_ns2 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rd[1]), .cpuIdx(cpuIdx), .nonSecure(nonSecure));
  cpuif_bpr_bank #(.HAS_SEC(1'b0), .REV(1)) u_dut_ns1 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rd[2]), .cpuIdx(cpuIdx), .nonSecure(nonSecure));

  function automatic int mRead(int c, int a, int i, bit ns);
    if (i >= NCPU) return 0;
    case (a)
      'h04: return mMask[c][i];
      'h08: return (cfgSec[c] != 0 && ns) ? mAlias[c][i] : mSec[c][i];
      'h1C: return (cfgSec[c] != 0 && !ns) ? mAlias[c][i] : 0;
      default: return 0;
    endcase
  endfunction

  task automatic mWrite(int c, int a, int d, int i, bit ns);
    int lo;
    int cl;
    if (i >= NCPU) return;
    lo = d & 7;
    cl = (lo < 1) ? 1 : lo;
    case (a)
      'h04: mMask[c][i] = d & 255;
      'h08: begin
        if (cfgSec[c] != 0 && ns) mAlias[c][i] = cl;
        else begin
          mSec[c][i] = lo;
          if (cfgSec[c] == 0 && cfgRev[c] >= 2) mAlias[c][i] = lo;
        end
      end
      'h1C: begin
        if (cfgSec[c] != 0) begin
          if (!ns) mAlias[c][i] = cl;
        end else if (cfgRev[c] >= 2) begin
          mAlias[c][i] = cl;
          mSec[c][i] = cl;
        end
      end
      default: ;
    endcase
  endtask

  // one bus cycle: compare reads of the current state, then apply the write
  task automatic op(int a, bit we, int d, int i, bit ns, string tag);
    @(negedge clk);
    addr = 8'(a); wrEn = we; wrData = 32'(d); cpuIdx = 3'(i); nonSecure = ns;
    #1;
    for (int c = 0; c < NCFG; c++) begin
      int exp;
      exp = mRead(c, a, i, ns);
      checks++;
      if (rd[c] !== 32'(exp)) begin
        failures++;
        $display("FAIL %s cfg%0d addr=%0h idx=%0d ns=%0b actual=%0h expected=%0h",
                 tag, c, a, i, ns, rd[c], exp);
      end
    end
    if (we) for (int c = 0; c < NCFG; c++) mWrite(c, a, d, i, ns);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lfsr;
    int offs [4] = '{'h04, 'h08, 'h1C, 'h10};
    for (int c = 0; c < NCFG; c++)
      for (int i = 0; i < 8; i++) begin
        mMask[c][i] = 0; mSec[c][i] = 0; mAlias[c][i] = 1;
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset values
    for (int i = 0; i < NCPU; i++) begin
      op('h04, 0, 0, i, 0, "R11");
      op('h08, 0, 0, i, 0, "R11");
      op('h08, 0, 0, i, 1, "R11");
    end
    // R1 priority mask
    op('h04, 1, 'h1234A5, 0, 0, "R1");
    op('h04, 1, 'h3C, 1, 1, "R1");
    op('h04, 0, 0, 0, 0, "R1");
    op('h04, 0, 0, 1, 0, "R1");
    // R2 three-bit binary point
    op('h08, 1, 'hFFFFFFFD, 0, 0, "R2");
    op('h08, 0, 0, 0, 0, "R2");
    // R3 banking by security state
    op('h08, 1, 6, 0, 1, "R3");
    op('h08, 0, 0, 0, 0, "R3");
    op('h08, 0, 0, 0, 1, "R3");
    // R4 clamp of the non-secure copy
    op('h08, 1, 0, 0, 1, "R4");
    op('h08, 0, 0, 0, 1, "R4");
    op('h1C, 1, 8, 3, 0, "R4");
    op('h08, 0, 0, 3, 1, "R4");
    // R5 alias read visibility
    op('h1C, 0, 0, 3, 0, "R5");
    op('h1C, 0, 0, 3, 1, "R5");
    // R6 secure write reaches alias, non-secure ignored
    op('h1C, 1, 5, 2, 0, "R6");
    op('h1C, 1, 7, 2, 1, "R6");
    op('h1C, 0, 0, 2, 0, "R6");
    op('h08, 0, 0, 2, 1, "R6");
    // R7 / R8 alias write in configurations without security
    op('h08, 1, 4, 4, 0, "R7");
    op('h08, 0, 0, 4, 0, "R8");
    op('h1C, 1, 0, 4, 0, "R7");
    op('h08, 0, 0, 4, 0, "R7");
    op('h1C, 1, 6, 4, 1, "R8");
    op('h08, 0, 0, 4, 0, "R8");
    op('h08, 1, 0, 5, 0, "R7");
    op('h08, 0, 0, 5, 0, "R7");
    // R9 per-processor isolation
    op('h04, 1, 'h77, 5, 0, "R9");
    for (int i = 0; i < NCPU; i++) op('h04, 0, 0, i, 0, "R9");
    // R10 out-of-range index
    op('h04, 1, 'hFF, 6, 0, "R10");
    op('h08, 1, 7, 7, 0, "R10");
    op('h1C, 1, 7, 6, 0, "R10");
    op('h04, 0, 0, 6, 0, "R10");
    op('h04, 0, 0, 0, 0, "R10");
    op('h08, 0, 0, 0, 0, "R10");
    // R12 unmapped offsets
    op('h0C, 1, 'hFF, 0, 0, "R12");
    op('h20, 1, 'hFF, 0, 0, "R12");
    op('h0C, 0, 0, 0, 0, "R12");
    op('h04, 0, 0, 0, 0, "R12");
    // mixed sweep, all requirements together
    lfsr = 'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 'hB400 : 0)) & 'hFFFF;
      op(offs[lfsr & 3], ((lfsr >> 2) & 1) != 0, lfsr >> 5, (lfsr >> 8) & 7,
         ((lfsr >> 11) & 1) != 0, "R3");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule